// File: doc/BRIEF.md
# Palette Write Sequencer with Color Lookup

This block holds a color lookup table of 256 entries. Each entry has an 8-bit red, an 8-bit green and an 8-bit blue value. A host loads the table through a small register window. It first writes a starting entry number to the index register. It then pushes color bytes into the colormap data register. Each byte fills the next channel of the current entry, in the order red, green, blue. After the blue byte the entry number moves on by one, wrapping from 255 to 0. A colormap write may carry a single byte or a full 32-bit word. A word is split into four bytes and fed in from the most significant byte down, one byte per clock. A single word can therefore complete one entry and begin the next.

A separate lookup port turns an 8-bit pixel code into a 24-bit RGB word for the scanout path. This port runs independently of the host port. Each accepted colormap write raises a one-cycle change pulse. A display engine can use that pulse to schedule a full redraw.

Top module: `clut_loader`

## Requirements
- R1: A write accepted at offset 0x0 loads bus_wdata[7:0] as the current entry number and returns the channel phase to red. It does not pulse pal_changed, and bus_ready stays high.
- R2: Successive colormap bytes fill the red, green and blue channels of the current entry in that order. After the blue byte the entry number increments modulo 256 and the phase returns to red.
- R3: A byte-sized colormap write (offset 0x4, bus_word=0) supplies exactly one color byte, taken from bus_wdata[7:0]. Bits 31:8 are ignored.
- R4: A word colormap write (offset 0x4, bus_word=1) supplies four color bytes in the order bits 31:24, 23:16, 15:8, 7:0. Each byte advances the phase, so one word may span two entries.
- R5: After a colormap write is accepted, bus_ready is low for one cycle per byte: one cycle for a byte write, four cycles for a word write. Any write presented while bus_ready is low has no effect.
- R6: Reads of either register return zero on bus_rdata.
- R7: Reset clears every channel of every entry to zero, sets the entry number to 0 and sets the phase to red. pix_rgb reads zero and bus_ready is high.
- R8: pix_rgb shows red in bits 23:16, green in 15:8 and blue in 7:0 for the entry named by pix_code. It appears one clock after pix_code is sampled.
- R9: pal_changed is high for exactly one cycle, in the cycle after a colormap write is accepted.
- R10: When a lookup samples the entry that a color byte updates at the same clock edge, it returns the value held before that update.
- R11: Writes to offsets other than 0x0 and 0x4 change neither the table, the entry number nor the phase, and they do not pulse pal_changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset within the register window |
| bus_word | input | 1 | Colormap write size: 1 = 32-bit word, 0 = byte |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (always zero) |
| bus_ready | output | 1 | High when a write can be accepted |
| pix_code | input | 8 | Pixel code to look up |
| pix_rgb | output | 24 | Looked-up color {red, green, blue} |
| pal_changed | output | 1 | One-cycle pulse after a colormap write is accepted |

## Verification
The host port and the lookup port have fixed latencies. The cycle numbers below count from edge E0, the edge at which a write is accepted.

- pal_changed and the drop of bus_ready are due at E0.
- The first color byte lands at E1.
- The table holds the last byte of a word at E4. bus_ready is high again after E4.
- A lookup result shows one edge after pix_code is sampled.

The bench drives inputs on the falling edge and samples on the falling edge. It counts the low-ready falling edges after each write and compares the count with the byte count. It reads the table only through the lookup port, and only after the host port reports ready again. In the collision case it checks the lookup result at E1 and again at E2, to show the old value and then the new one.

// File: rtl/clut_pkg.sv
package clut_pkg;

  typedef enum logic [1:0] {
    PH_RED = 2'd0,
    PH_GRN = 2'd1,
    PH_BLU = 2'd2
  } phase_e;

  localparam int unsigned CHANNELS = 3;
  localparam int unsigned CHAN_W   = 8;
  localparam int unsigned RGB_W    = CHANNELS * CHAN_W;

endpackage

// File: rtl/clut_bus_decode.sv
module clut_bus_decode #(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned IDX_OFS = 0,
  parameter int unsigned MAP_OFS = 4
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              port_ready,
  output logic              idx_wr,
  output logic              map_wr
);

  logic wr_ok;

  always_comb begin
    wr_ok  = bus_sel & bus_we & port_ready;
    idx_wr = wr_ok & (bus_addr == ADDR_W'(IDX_OFS));
    map_wr = wr_ok & (bus_addr == ADDR_W'(MAP_OFS));
  end

endmodule

// File: rtl/clut_byte_feeder.sv
module clut_byte_feeder #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_word,
  input  logic [DATA_W-1:0] load_data,
  output logic              byte_vld,
  output logic [7:0]        byte_val,
  output logic              ready
);

  localparam int unsigned NBYTES = DATA_W / 8;
  localparam int unsigned CNT_W  = $clog2(NBYTES + 1);

  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              shreg_en;

  always_comb begin
    byte_vld = (cnt_q != '0);
    byte_val = shreg_q[DATA_W-1 -: 8];
    ready    = ~byte_vld;
    shreg_d  = shreg_q;
    cnt_d    = cnt_q;
    shreg_en = 1'b0;
    if (load) begin
      shreg_en = 1'b1;
      if (load_word) begin
        shreg_d = load_data;
        cnt_d   = CNT_W'(NBYTES);
      end else begin
        shreg_d = {load_data[7:0], {(DATA_W-8){1'b0}}};
        cnt_d   = CNT_W'(1);
      end
    end else if (byte_vld) begin
      shreg_en = 1'b1;
      shreg_d  = {shreg_q[DATA_W-9:0], 8'h00};
      cnt_d    = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (shreg_en) begin
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/clut_phase_seq.sv
module clut_phase_seq
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idx_load,
  input  logic [IDX_W-1:0]    idx_val,
  input  logic                byte_vld,
  output logic [CHANNELS-1:0] wr_en,
  output logic [IDX_W-1:0]    wr_idx
);

  phase_e           phase_q, phase_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             st_en;

  always_comb begin
    wr_idx = idx_q;
    wr_en  = '0;
    if (byte_vld) begin
      unique case (phase_q)
        PH_RED:  wr_en = 3'b001;
        PH_GRN:  wr_en = 3'b010;
        PH_BLU:  wr_en = 3'b100;
        default: wr_en = '0;
      endcase
    end
  end

  always_comb begin
    phase_d = phase_q;
    idx_d   = idx_q;
    st_en   = idx_load | byte_vld;
    if (idx_load) begin
      idx_d   = idx_val;
      phase_d = PH_RED;
    end else if (byte_vld) begin
      unique case (phase_q)
        PH_RED: phase_d = PH_GRN;
        PH_GRN: phase_d = PH_BLU;
        PH_BLU: begin
          phase_d = PH_RED;
          idx_d   = idx_q + IDX_W'(1);
        end
        default: phase_d = PH_RED;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RED;
      idx_q   <= '0;
    end else if (st_en) begin
      phase_q <= phase_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/clut_table.sv
module clut_table
  import clut_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [CHAN_W-1:0]   wr_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [RGB_W-1:0]    rd_rgb
);

  localparam int unsigned ENTRIES = 1 << IDX_W;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic [CHAN_W-1:0] mem [ENTRIES];
    logic [CHAN_W-1:0] rd_q, rd_d;

    always_comb rd_d = mem[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < ENTRIES; e++) mem[e] <= '0;
      end else if (wr_en[ch]) begin
        mem[wr_idx] <= wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_d;
    end

    assign rd_rgb[(CHANNELS-1-ch)*CHAN_W +: CHAN_W] = rd_q;
  end

endmodule

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned IDX_OFS = 0,
  parameter int unsigned MAP_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_word,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  input  logic [IDX_W-1:0]  pix_code,
  output logic [RGB_W-1:0]  pix_rgb,
  output logic              pal_changed
);

  logic [1:0]          rst_pipe_q;
  logic                rst_int_n;
  logic                idx_wr, map_wr;
  logic                byte_vld;
  logic [7:0]          byte_val;
  logic [CHANNELS-1:0] wr_en;
  logic [IDX_W-1:0]    wr_idx;
  logic                chg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  clut_bus_decode #(
    .ADDR_W (ADDR_W),
    .IDX_OFS(IDX_OFS),
    .MAP_OFS(MAP_OFS)
  ) u_dec (
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .port_ready(bus_ready),
    .idx_wr    (idx_wr),
    .map_wr    (map_wr)
  );

  clut_byte_feeder #(.DATA_W(DATA_W)) u_feed (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (map_wr),
    .load_word(bus_word),
    .load_data(bus_wdata),
    .byte_vld (byte_vld),
    .byte_val (byte_val),
    .ready    (bus_ready)
  );

  clut_phase_seq #(.IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .idx_load(idx_wr),
    .idx_val (bus_wdata[IDX_W-1:0]),
    .byte_vld(byte_vld),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx)
  );

  clut_table #(.IDX_W(IDX_W)) u_tab (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(byte_val),
    .rd_idx (pix_code),
    .rd_rgb (pix_rgb)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) chg_q <= 1'b0;
    else            chg_q <= map_wr;
  end

  assign pal_changed = chg_q;
  assign bus_rdata   = '0;

endmodule

// File: rtl/clut_loader_chk.sv
module clut_loader_chk #(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned IDX_OFS = 0,
  parameter int unsigned MAP_OFS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_word,
  input logic              bus_ready,
  input logic              pal_changed
);

  logic acc_map, acc_idx;
  assign acc_map = bus_sel & bus_we & bus_ready & (bus_addr == ADDR_W'(MAP_OFS));
  assign acc_idx = bus_sel & bus_we & bus_ready & (bus_addr == ADDR_W'(IDX_OFS));

  p_word_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_map && bus_word) |-> ##1 !bus_ready ##1 !bus_ready ##1 !bus_ready
                              ##1 !bus_ready ##1 bus_ready);

  p_byte_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_map && !bus_word) |=> !bus_ready ##1 bus_ready);

  p_chg_after_map_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_map |=> pal_changed);

  p_chg_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pal_changed |=> !pal_changed);

  p_no_chg_on_index_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc_idx |=> !pal_changed);

  p_chg_needs_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pal_changed |-> $past(acc_map));

endmodule

bind clut_loader clut_loader_chk #(
  .ADDR_W (ADDR_W),
  .IDX_OFS(IDX_OFS),
  .MAP_OFS(MAP_OFS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .bus_sel    (bus_sel),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .bus_word   (bus_word),
  .bus_ready  (bus_ready),
  .pal_changed(pal_changed)
);

// File: tb/clut_loader_bench.sv
module clut_loader_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we, bus_word;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        bus_ready;
  logic [7:0]  pix_code;
  logic [23:0] pix_rgb;
  logic        pal_changed;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] midx;
  int         mph;

  always #2 clk = ~clk;

  clut_loader u_clut_loader (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_word(bus_word), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_ready(bus_ready), .pix_code(pix_code),
    .pix_rgb(pix_rgb), .pal_changed(pal_changed)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      mr[i] = 8'h00; mg[i] = 8'h00; mb[i] = 8'h00;
    end
    midx = 8'h00;
    mph  = 0;
  endtask

  task automatic model_byte(logic [7:0] b);
    case (mph)
      0: begin mr[midx] = b; mph = 1; end
      1: begin mg[midx] = b; mph = 2; end
      default: begin mb[midx] = b; mph = 0; midx = midx + 8'd1; end
    endcase
  endtask

  function automatic logic [31:0] model_rgb(logic [7:0] e);
    return {8'h00, mr[e], mg[e], mb[e]};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bus_sel = 1'b0; bus_we = 1'b0; bus_word = 1'b0;
    bus_addr = '0; bus_wdata = '0; pix_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  task automatic do_write(input logic [4:0] addr, input logic [31:0] data,
                          input logic word, output int busy, output logic chg);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = addr;
    bus_word = word; bus_wdata = data;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    chg  = pal_changed;
    busy = 0;
    while (!bus_ready) begin
      busy++;
      @(negedge clk);
    end
    if (addr == 5'h00) begin
      midx = data[7:0]; mph = 0;
    end else if (addr == 5'h04) begin
      if (word) begin
        model_byte(data[31:24]); model_byte(data[23:16]);
        model_byte(data[15:8]);  model_byte(data[7:0]);
      end else begin
        model_byte(data[7:0]);
      end
    end
  endtask

  task automatic lookup(input logic [7:0] code, output logic [31:0] rgb);
    @(negedge clk);
    pix_code = code;
    @(posedge clk);
    @(negedge clk);
    rgb = {8'h00, pix_rgb};
  endtask

  task automatic chk_entry(string req, logic [7:0] e);
    logic [31:0] v;
    lookup(e, v);
    chk(req, $sformatf("entry %0d", e), v, model_rgb(e));
  endtask

  task automatic t_reset_state();
    chk("R7", "ready after reset", {31'd0, bus_ready}, 32'd1);
    chk("R7", "pal_changed after reset", {31'd0, pal_changed}, 32'd0);
    chk("R7", "pix_rgb after reset", {8'h00, pix_rgb}, 32'd0);
    chk_entry("R7", 8'd0);
    chk_entry("R7", 8'd128);
    chk_entry("R7", 8'd255);
  endtask

  task automatic t_byte_sequence();
    int busy; logic chg;
    do_write(5'h00, 32'h0000_0005, 1'b0, busy, chg);
    chk("R1", "index write busy", busy, 0);
    chk("R1", "index write pulse", {31'd0, chg}, 0);
    do_write(5'h04, 32'hABCD_EF11, 1'b0, busy, chg);
    chk("R5", "byte busy cycles", busy, 1);
    chk("R9", "byte write pulse", {31'd0, chg}, 1);
    do_write(5'h04, 32'h1234_5622, 1'b0, busy, chg);
    do_write(5'h04, 32'hFFFF_FF33, 1'b0, busy, chg);
    chk("R8", "pulse gone", {31'd0, pal_changed}, 0);
    chk_entry("R2", 8'd5);
    chk("R3", "entry 5 value", model_rgb(8'd5), 32'h0011_2233);
    do_write(5'h04, 32'h0000_0044, 1'b0, busy, chg);
    chk_entry("R2", 8'd6);
  endtask

  task automatic t_index_wrap();
    int busy; logic chg;
    do_write(5'h00, 32'h0000_00FF, 1'b0, busy, chg);
    do_write(5'h04, 32'h01, 1'b0, busy, chg);
    do_write(5'h04, 32'h02, 1'b0, busy, chg);
    do_write(5'h04, 32'h03, 1'b0, busy, chg);
    do_write(5'h04, 32'h04, 1'b0, busy, chg);
    chk_entry("R2", 8'd255);
    chk_entry("R2", 8'd0);
  endtask

  task automatic t_word_writes();
    int busy; logic chg;
    do_write(5'h00, 32'h0000_000A, 1'b0, busy, chg);
    do_write(5'h04, 32'hA1B2_C3D4, 1'b1, busy, chg);
    chk("R5", "word busy cycles", busy, 4);
    chk("R9", "word write pulse", {31'd0, chg}, 1);
    do_write(5'h04, 32'hE5F6_0718, 1'b1, busy, chg);
    chk_entry("R4", 8'd10);
    chk_entry("R4", 8'd11);
    chk_entry("R4", 8'd12);
    chk("R4", "entry 11 value", model_rgb(8'd11), 32'h00D4_E5F6);
  endtask

  task automatic t_index_resets_phase();
    int busy; logic chg;
    do_write(5'h00, 32'h0000_001E, 1'b0, busy, chg);
    do_write(5'h04, 32'h55, 1'b0, busy, chg);
    do_write(5'h00, 32'h0000_001E, 1'b0, busy, chg);
    do_write(5'h04, 32'h66, 1'b0, busy, chg);
    chk_entry("R1", 8'd30);
  endtask

  task automatic t_busy_ignore();
    int busy; logic chg;
    do_write(5'h00, 32'h0000_0028, 1'b0, busy, chg);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h04;
    bus_word = 1'b1; bus_wdata = 32'h0102_0304;
    @(posedge clk);
    @(negedge clk);
    bus_addr = 5'h00; bus_word = 1'b0; bus_wdata = 32'h0000_0080;
    @(posedge clk);
    @(negedge clk);
    bus_addr = 5'h04; bus_wdata = 32'h0000_00EE;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    while (!bus_ready) @(negedge clk);
    model_byte(8'h01); model_byte(8'h02); model_byte(8'h03); model_byte(8'h04);
    do_write(5'h04, 32'h99, 1'b0, busy, chg);
    chk_entry("R5", 8'd40);
    chk_entry("R5", 8'd41);
  endtask

  task automatic t_reads();
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 5'h00;
    #1 chk("R6", "index read", bus_rdata, 32'd0);
    bus_addr = 5'h04;
    #1 chk("R6", "colormap read", bus_rdata, 32'd0);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic t_other_offsets();
    int busy; logic chg;
    do_write(5'h00, 32'h0000_0032, 1'b0, busy, chg);
    do_write(5'h08, 32'hDEAD_BEEF, 1'b1, busy, chg);
    chk("R11", "offset 8 pulse", {31'd0, chg}, 0);
    chk("R11", "offset 8 busy", busy, 0);
    do_write(5'h10, 32'h0000_0077, 1'b0, busy, chg);
    chk("R11", "offset 0x10 pulse", {31'd0, chg}, 0);
    do_write(5'h04, 32'h12, 1'b0, busy, chg);
    chk_entry("R11", 8'd50);
  endtask

  task automatic t_collision();
    int busy; logic chg;
    do_write(5'h00, 32'h14, 1'b0, busy, chg);
    do_write(5'h04, 32'h0010_2030, 1'b1, busy, chg);
    do_write(5'h00, 32'h14, 1'b0, busy, chg);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 5'h04;
    bus_word = 1'b0; bus_wdata = 32'hAA;
    pix_code = 8'd20;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10", "same-edge lookup", {8'h00, pix_rgb}, model_rgb(8'd20));
    model_byte(8'hAA);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "following lookup", {8'h00, pix_rgb}, model_rgb(8'd20));
  endtask

  task automatic t_mid_reset();
    int busy; logic chg;
    do_reset();
    chk_entry("R7", 8'd5);
    chk_entry("R7", 8'd11);
    do_write(5'h04, 32'h3C, 1'b0, busy, chg);
    chk_entry("R7", 8'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    do_reset();
    t_reset_state();
    t_byte_sequence();
    t_index_wrap();
    t_word_writes();
    t_index_resets_phase();
    t_busy_ignore();
    t_reads();
    t_other_offsets();
    t_collision();
    t_mid_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule